// File: doc/BRIEF.md
# Layered Port Range Encoder

This block turns a 16-bit transport port number into a fixed-width binary code built from three layers. These codes are shorter than the port ranges they stand for, so a classification table can store one entry for each range and needs no expansion of ranges into prefixes. The three layers are a one-bit class that separates the well-known ports from the ephemeral ports, an exact-match code found through a hash table indexed by the low bits of the port, and an arbitrary-range segment code found by walking a five-way search tree. The three lookups run independently and their results are joined into one word. A lookup that finds nothing gives all zeros in its layer.

A key enters on a valid/ready handshake. Only one key is in flight: `in_ready` is high only while the block is idle, so a key offered at any other time is held off until the previous result has been taken. The result leaves on a second valid/ready handshake. While `out_valid` is high and `out_ready` is low, the code is frozen. The hash table and the tree nodes are loaded through plain write ports. The defaults match a destination-port layout: 1 class bit, 9 exact-match bits and 8 segment bits in a 24-bit word. Other layouts are set through parameters.

Top module: `port_range_encoder`

## Requirements
- R1: `in_ready` is high exactly when no key is in flight and no result is waiting. A key is taken only on a cycle where `in_valid` and `in_ready` are both high. While a key is being searched or its result is waiting, `in_valid` and `in_key` have no effect.
- R2: The top bit of `out_code` is 1 when the accepted port is 1024 or more, and 0 when it is 1023 or less.
- R3: The exact-match field is `out_code[CODE_W-2 -: EM_W]`. The hash index is `port[HASH_K-1:0]`. The stored code appears in the field only when the entry at that index is marked valid and its stored 16-bit tag equals the whole port. In every other case the field is all zeros.
- R4: The segment field is `out_code[CODE_W-2-EM_W -: AR_W]`. The search starts at node 0. A node holds four ascending bounds at bits `[16*j +: 16]`, j = 0..3. It also holds five slots of `AR_W+1` bits each, starting at bit 64: the top bit of a slot marks a leaf and the low `AR_W` bits hold either a code or a child node number. The slot taken is the number of bounds that are less than or equal to the port. A leaf's value becomes the field.
- R5: If no leaf is reached within `MAX_DEPTH` node visits, the segment field is all zeros.
- R6: All bits of `out_code` below the three layers are zero.
- R7: `out_valid` rises exactly d clock edges after the accepting edge, where d is the number of tree nodes visited (1 to `MAX_DEPTH`).
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_code` is unchanged. After the edge that completes the output handshake, `out_valid` is low and `in_ready` is high.
- R9: After reset, `out_valid` is low, `in_ready` is high, every hash entry is invalid and every tree node is all zeros. With the tables in this state, a search loops on node 0 until the depth limit, so the segment field is zero after `MAX_DEPTH` visits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Key offered |
| in_ready | output | 1 | Block idle, key can be taken |
| in_key | input | 16 | Port number to encode |
| out_valid | output | 1 | Code available |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | CODE_W | Layered code |
| em_we | input | 1 | Hash entry write strobe |
| em_waddr | input | HASH_K | Hash entry index |
| em_wvalid | input | 1 | Valid flag written to the entry |
| em_wtag | input | 16 | Full-port tag written to the entry |
| em_wcode | input | EM_W | Exact-match code written to the entry |
| tr_we | input | 1 | Tree node write strobe |
| tr_waddr | input | NODE_AW | Tree node number |
| tr_wnode | input | 4*16+5*(AR_W+1) | Packed node: bounds, then slots |

## Verification
The ports used are chosen to sit on each side of every boundary the lookups depend on. Ports 1023 and 1024 separate the class bit. Ports equal to a tree bound check that the comparison is less-than-or-equal and not strict. Ports one below a bound fall into the lower slot. For the hash, there are hits, a port that shares an index with a stored entry but fails the tag check, and an entry written with its valid flag clear. Together these separate a correct tag compare from one that trusts the index alone. The tree is walked to depths of one, two, three and six. The six-visit walks include one that finds its leaf on the last visit and one that does not, which pins the depth limit and the latency exactly. A run with empty tables right after reset, a key changed during a search, and an output held under back-pressure cover the handshake rules.

// File: rtl/port_enc_pkg.sv
package port_enc_pkg;
  localparam int KEY_W     = 16;
  localparam int HILO_EDGE = 1024;
  localparam int TREE_WAYS = 5;
  localparam int TREE_BNDS = TREE_WAYS - 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_HOLD   = 2'd2
  } enc_state_e;
endpackage

// File: rtl/em_hash_lookup.sv
module em_hash_lookup
  import port_enc_pkg::*;
#(
  parameter int HASH_K = 6,
  parameter int EM_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HASH_K-1:0] wr_idx,
  input  logic              wr_vld,
  input  logic [KEY_W-1:0]  wr_tag,
  input  logic [EM_W-1:0]   wr_code,
  input  logic              lk_en,
  input  logic [KEY_W-1:0]  lk_key,
  output logic [EM_W-1:0]   res_code
);
  localparam int DEPTH = 1 << HASH_K;

  logic              vld_q  [DEPTH];
  logic [KEY_W-1:0]  tag_q  [DEPTH];
  logic [EM_W-1:0]   code_q [DEPTH];
  logic [EM_W-1:0]   res_q;
  logic [HASH_K-1:0] idx;
  logic              hit;

  assign idx      = lk_key[HASH_K-1:0];
  assign hit      = vld_q[idx] && (tag_q[idx] == lk_key);
  assign res_code = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i]  <= 1'b0;
        tag_q[i]  <= '0;
        code_q[i] <= '0;
      end
      res_q <= '0;
    end else begin
      if (wr_en) begin
        vld_q[wr_idx]  <= wr_vld;
        tag_q[wr_idx]  <= wr_tag;
        code_q[wr_idx] <= wr_code;
      end
      if (lk_en) res_q <= hit ? code_q[idx] : '0;
    end
  end
endmodule

// File: rtl/seg_tree_search.sv
module seg_tree_search
  import port_enc_pkg::*;
#(
  parameter int AR_W      = 8,
  parameter int NODE_AW   = 4,
  parameter int MAX_DEPTH = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NODE_AW-1:0] wr_addr,
  input  logic [TREE_BNDS*KEY_W+TREE_WAYS*(AR_W+1)-1:0] wr_node,
  input  logic               start,
  input  logic [KEY_W-1:0]   key,
  output logic               done,
  output logic [AR_W-1:0]    seg_code
);
  localparam int SLOT_W    = AR_W + 1;
  localparam int SLOT_BASE = TREE_BNDS * KEY_W;
  localparam int NODE_W    = SLOT_BASE + TREE_WAYS * SLOT_W;
  localparam int NUM_NODES = 1 << NODE_AW;
  localparam int DEPTH_W   = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam int SEL_W     = $clog2(TREE_WAYS + 1);

  logic [NODE_W-1:0]  node_q [NUM_NODES];
  logic               busy_q;
  logic [NODE_AW-1:0] cur_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [KEY_W-1:0]   key_q;

  logic [NODE_W-1:0]    node;
  logic [TREE_BNDS-1:0] le;
  logic [SEL_W-1:0]     sel;
  logic                 leaf;
  logic [AR_W-1:0]      val;

  assign node = node_q[cur_q];

  for (genvar j = 0; j < TREE_BNDS; j++) begin : g_cmp
    assign le[j] = node[j*KEY_W +: KEY_W] <= key_q;
  end

  always_comb begin
    sel = '0;
    for (int j = 0; j < TREE_BNDS; j++) sel = sel + SEL_W'(le[j]);
  end

  assign leaf     = node[SLOT_BASE + int'(sel)*SLOT_W + AR_W];
  assign val      = node[SLOT_BASE + int'(sel)*SLOT_W +: AR_W];
  assign done     = busy_q && (leaf || (depth_q == DEPTH_W'(MAX_DEPTH - 1)));
  assign seg_code = leaf ? val : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_NODES; i++) node_q[i] <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      depth_q <= '0;
      key_q   <= '0;
    end else begin
      if (wr_en) node_q[wr_addr] <= wr_node;
      if (start) begin
        busy_q  <= 1'b1;
        cur_q   <= '0;
        depth_q <= '0;
        key_q   <= key;
      end else if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
        end else begin
          cur_q   <= val[NODE_AW-1:0];
          depth_q <= depth_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/port_range_encoder.sv
module port_range_encoder
  import port_enc_pkg::*;
#(
  parameter int HASH_K    = 6,
  parameter int EM_W      = 9,
  parameter int AR_W      = 8,
  parameter int CODE_W    = 24,
  parameter int NODE_AW   = 4,
  parameter int MAX_DEPTH = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [15:0]        in_key,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CODE_W-1:0]  out_code,
  input  logic               em_we,
  input  logic [HASH_K-1:0]  em_waddr,
  input  logic               em_wvalid,
  input  logic [15:0]        em_wtag,
  input  logic [EM_W-1:0]    em_wcode,
  input  logic               tr_we,
  input  logic [NODE_AW-1:0] tr_waddr,
  input  logic [4*16+5*(AR_W+1)-1:0] tr_wnode
);
  localparam int USED_W = 1 + EM_W + AR_W;
  localparam int PAD_W  = CODE_W - USED_W;

  enc_state_e        st_q;
  logic              accept;
  logic              hl_q;
  logic [EM_W-1:0]   em_code;
  logic [AR_W-1:0]   seg_code;
  logic              tree_done;
  logic [CODE_W-1:0] joined;
  logic [CODE_W-1:0] code_q;

  assign in_ready  = (st_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign out_valid = (st_q == ST_HOLD);
  assign out_code  = code_q;

  em_hash_lookup #(.HASH_K(HASH_K), .EM_W(EM_W)) u_em (
    .clk(clk), .rst_n(rst_n),
    .wr_en(em_we), .wr_idx(em_waddr), .wr_vld(em_wvalid),
    .wr_tag(em_wtag), .wr_code(em_wcode),
    .lk_en(accept), .lk_key(in_key), .res_code(em_code)
  );

  seg_tree_search #(.AR_W(AR_W), .NODE_AW(NODE_AW), .MAX_DEPTH(MAX_DEPTH)) u_tree (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tr_we), .wr_addr(tr_waddr), .wr_node(tr_wnode),
    .start(accept), .key(in_key),
    .done(tree_done), .seg_code(seg_code)
  );

  if (PAD_W > 0) begin : g_pad
    assign joined = {hl_q, em_code, seg_code, {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign joined = {hl_q, em_code, seg_code};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hl_q   <= 1'b0;
      code_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          hl_q <= (in_key >= 16'(HILO_EDGE));
          st_q <= ST_SEARCH;
        end
        ST_SEARCH: if (tree_done) begin
          code_q <= joined;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/port_range_encoder_chk.sv
module port_range_encoder_chk #(
  parameter int CODE_W    = 24,
  parameter int PAD_W     = 6,
  parameter int MAX_DEPTH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       in_key,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code
);
  logic [15:0] cap_key;
  logic        trk;
  logic [7:0]  wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_key  <= '0;
      trk      <= 1'b0;
      wait_cnt <= '0;
    end else if (in_valid && in_ready) begin
      cap_key  <= in_key;
      trk      <= 1'b1;
      wait_cnt <= '0;
    end else if (trk) begin
      if (out_valid) trk <= 1'b0;
      else wait_cnt <= wait_cnt + 1'b1;
    end
  end

  a_r1_ready_low_while_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r2_class_bit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code[CODE_W-1] == (cap_key >= 16'd1024)));

  a_r7_search_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= 8'(MAX_DEPTH));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  if (PAD_W > 0) begin : g_pad_chk
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_code[PAD_W-1:0] == '0));
  end
endmodule

bind port_range_encoder port_range_encoder_chk #(
  .CODE_W(CODE_W), .PAD_W(PAD_W), .MAX_DEPTH(MAX_DEPTH)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_key(in_key), .out_valid(out_valid), .out_ready(out_ready),
  .out_code(out_code)
);

// File: tb/test_port_range_encoder.sv
`timescale 1ns/1ps
module test_port_range_encoder;
  localparam int HASH_K = 6, EM_W = 9, AR_W = 8, CODE_W = 24, NODE_AW = 4;
  localparam int NODE_W = 64 + 5 * (AR_W + 1);
  localparam int NV = 18;

  // {key, class bit, exact-match code, segment code, node visits}
  localparam logic [37:0] VEC [NV] = '{
    {16'd80,    1'b0, 9'h055, 8'h11, 4'd1},
    {16'd443,   1'b0, 9'h1A3, 8'h11, 4'd1},
    {16'd53,    1'b0, 9'h101, 8'h11, 4'd1},
    {16'd1023,  1'b0, 9'h000, 8'h31, 4'd2},
    {16'd1024,  1'b1, 9'h000, 8'h31, 4'd2},
    {16'd1500,  1'b1, 9'h000, 8'h33, 4'd2},
    {16'd1999,  1'b1, 9'h000, 8'h35, 4'd2},
    {16'd2000,  1'b1, 9'h000, 8'h22, 4'd1},
    {16'd8080,  1'b1, 9'h000, 8'h53, 4'd2},
    {16'd8079,  1'b1, 9'h000, 8'h52, 4'd2},
    {16'd22,    1'b0, 9'h000, 8'h11, 4'd1},
    {16'd9500,  1'b1, 9'h000, 8'h6A, 4'd3},
    {16'd12000, 1'b1, 9'h000, 8'h7F, 4'd6},
    {16'd25000, 1'b1, 9'h000, 8'h00, 4'd6},
    {16'd65535, 1'b1, 9'h000, 8'h44, 4'd1},
    {16'd35000, 1'b1, 9'h000, 8'h00, 4'd2},
    {16'd0,     1'b0, 9'h000, 8'h11, 4'd1},
    {16'd3000,  1'b1, 9'h0C3, 8'h22, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] in_key = '0;
  logic in_ready, out_valid;
  logic [CODE_W-1:0] out_code;
  logic em_we = 1'b0, em_wvalid = 1'b0;
  logic [HASH_K-1:0] em_waddr = '0;
  logic [15:0] em_wtag = '0;
  logic [EM_W-1:0] em_wcode = '0;
  logic tr_we = 1'b0;
  logic [NODE_AW-1:0] tr_waddr = '0;
  logic [NODE_W-1:0] tr_wnode = '0;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  port_range_encoder i_port_range_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .em_we(em_we), .em_waddr(em_waddr),
    .em_wvalid(em_wvalid), .em_wtag(em_wtag), .em_wcode(em_wcode),
    .tr_we(tr_we), .tr_waddr(tr_waddr), .tr_wnode(tr_wnode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [8:0] lf(input logic [7:0] v);
    return {1'b1, v};
  endfunction
  function automatic logic [8:0] ch(input int n);
    return {1'b0, 8'(n)};
  endfunction
  function automatic logic [NODE_W-1:0] mk_node(input logic [15:0] b0, b1, b2, b3,
      input logic [8:0] s0, s1, s2, s3, s4);
    return {s4, s3, s2, s1, s0, b3, b2, b1, b0};
  endfunction

  task automatic em_put(input int idx, input logic v, input logic [15:0] tag, input logic [8:0] c);
    @(negedge clk);
    em_we = 1'b1; em_waddr = HASH_K'(idx); em_wvalid = v; em_wtag = tag; em_wcode = c;
    @(negedge clk);
    em_we = 1'b0;
  endtask

  task automatic tr_put(input int a, input logic [NODE_W-1:0] n);
    @(negedge clk);
    tr_we = 1'b1; tr_waddr = NODE_AW'(a); tr_wnode = n;
    @(negedge clk);
    tr_we = 1'b0;
  endtask

  // Offers a key; with alt set, keeps in_valid high with a different key during the search.
  task automatic run_key(input logic [15:0] k, input logic alt, output logic [CODE_W-1:0] code,
      output int lat);
    @(negedge clk);
    in_key = k; in_valid = 1'b1;
    check("R1 ready when idle", 32'(in_ready), 32'd1);
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    if (alt) in_key = 16'd80; else in_valid = 1'b0;
    check("R1 ready low in search", 32'(in_ready), 32'd0);
    while (!out_valid && lat < 20) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    code = out_code;
  endtask

  // Holds the result under back-pressure for one cycle, then takes it.
  task automatic take(input logic [CODE_W-1:0] seen);
    @(posedge clk);
    @(negedge clk);
    check("R8 valid held", 32'(out_valid), 32'd1);
    check("R8 code stable", 32'(out_code), 32'(seen));
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 valid drops", 32'(out_valid), 32'd0);
    check("R8 ready returns", 32'(in_ready), 32'd1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [CODE_W-1:0] code;
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 reset out_valid", 32'(out_valid), 32'd0);
    check("R9 reset in_ready", 32'(in_ready), 32'd1);

    // Empty tables after reset: tree loops on node 0 to the depth limit.
    run_key(16'd80, 1'b0, code, lat);
    check("R9 empty tables code", 32'(code), 32'h0);
    check("R5 empty depth limit latency", 32'(lat), 32'd6);
    take(code);
    run_key(16'd1024, 1'b0, code, lat);
    check("R2 class bit on empty tables", 32'(code), 32'h800000);
    take(code);

    em_put(16, 1'b1, 16'd80,   9'h055);
    em_put(59, 1'b1, 16'd443,  9'h1A3);
    em_put(53, 1'b1, 16'd53,   9'h101);
    em_put(22, 1'b0, 16'd22,   9'h0FF);
    em_put(56, 1'b1, 16'd3000, 9'h0C3);
    tr_put(0, mk_node(16'd1000, 16'd2000, 16'd5000, 16'd40000,
                      lf(8'h11), ch(1), lf(8'h22), ch(2), lf(8'h44)));
    tr_put(1, mk_node(16'd1200, 16'd1500, 16'd1800, 16'd1900,
                      lf(8'h31), lf(8'h32), lf(8'h33), lf(8'h34), lf(8'h35)));
    tr_put(2, mk_node(16'd6000, 16'd8080, 16'd9000, 16'd30000,
                      lf(8'h51), lf(8'h52), lf(8'h53), ch(3), lf(8'h00)));
    tr_put(3, mk_node(16'd10000, 16'd10000, 16'd10000, 16'd10000,
                      lf(8'h6A), ch(0), ch(0), ch(0), ch(4)));
    tr_put(4, mk_node(16'd0, 16'd0, 16'd0, 16'd0, ch(0), ch(0), ch(0), ch(0), ch(5)));
    tr_put(5, mk_node(16'd0, 16'd0, 16'd0, 16'd0, ch(0), ch(0), ch(0), ch(0), ch(6)));
    tr_put(6, mk_node(16'd20000, 16'd20000, 16'd20000, 16'd20000,
                      lf(8'h7F), ch(0), ch(0), ch(0), ch(7)));

    for (int i = 0; i < NV; i++) begin
      logic [15:0] k;
      logic hl;
      logic [8:0] em;
      logic [7:0] ar;
      int exp_lat;
      {k, hl, em, ar} = VEC[i][37:4];
      exp_lat = int'(VEC[i][3:0]);
      run_key(k, 1'b0, code, lat);
      check("R2 class bit", 32'(code[23]), 32'(hl));
      check("R3 exact-match field", 32'(code[22:14]), 32'(em));
      if (exp_lat == 6) check("R5 segment field at depth limit", 32'(code[13:6]), 32'(ar));
      else check("R4 segment field", 32'(code[13:6]), 32'(ar));
      check("R6 pad bits", 32'(code[5:0]), 32'd0);
      check("R7 latency", 32'(lat), 32'(exp_lat));
      take(code);
    end

    // Key offered during the search and while the result waits is not taken.
    run_key(16'd12000, 1'b1, code, lat);
    check("R1 key change ignored", 32'(code), 32'h801FC0);
    check("R7 latency with busy input", 32'(lat), 32'd6);
    @(negedge clk);
    check("R1 held while result waits", 32'(out_code), 32'h801FC0);
    take(code);

    // Back-to-back keys after release.
    run_key(16'd443, 1'b0, code, lat);
    check("R3 hit after back-to-back", 32'(code), {8'd0, 1'b0, 9'h1A3, 8'h11, 6'd0});
    take(code);

    summary();
  end
endmodule